// File: doc/BRIEF.md
# Per-Requester Way-Lockdown Tag Store for a Shared Cache

This block holds the tags, valid bits and replacement state of a shared set-associative cache that several processors use at once. Each lookup carries a physical address and the number of the processor that issued it. One cycle later the block reports whether the line is present and in which way. Data arrays, memory traffic and coherence belong to other blocks.

Every requester owns a way-lock mask with one bit per way. On a miss the replacement choice is restricted to the ways that the requester's mask leaves open. Lookups still hit in any way. When two processors are given disjoint masks, each has private ways, and a miss from one can never evict a line that the other installed. On a miss with an allowed way the block installs the new tag in that way and reports the address of any line it displaced. The masks are loaded through a one-cycle write port.

Top module: `lockdown_llc_tags`

## Requirements
- R1: After reset every line is invalid, every lock mask is 0x0000 (all ways open) and rsp_valid is 0. The first lookup of any address therefore misses.
- R2: A lookup whose tag matches a valid way in its set returns rsp_hit=1 and that way on rsp_way. This holds whether or not the requester's mask locks that way.
- R3: The address splits into a tag in bits [31:16], a set index in bits [15:5] and a byte offset in bits [4:0]. The offset does not affect the lookup. The page-color bits [15:12] are part of the set index, so addresses that differ only in color use different sets.
- R4: On a miss where some open way is invalid, the lowest-numbered open invalid way is filled and rsp_evict is 0.
- R5: Mask bit i set to 1 locks way i for that requester. A locked way is never chosen as the victim of that requester's miss. For example, the mask 0xFFFB leaves only way 2 open.
- R6: When every open way of the set is valid, the victim is the first open way found by counting up from the set's rotation pointer, wrapping past the last way. The pointer then moves to the victim plus one (mod 16). The pointer starts at 0 and changes only on such replacements.
- R7: A miss from a requester whose mask locks all 16 ways returns rsp_no_alloc=1 with rsp_evict=0 and rsp_way=0, and installs nothing.
- R8: When a valid line is replaced, rsp_evict is 1 and rsp_evict_addr equals {old tag, set index, 5'b0}. Otherwise rsp_evict_addr is 0.
- R9: Every response appears on the clock edge that follows the request. rsp_valid is 1 exactly in the cycle after a cycle with req_valid=1.
- R10: With cfg_we=1, cfg_mask is written to the mask register selected by cfg_id. Requests issued in later cycles use the new mask. Other requesters' masks are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_id | input | 2 | Requesting processor |
| req_addr | input | 32 | Physical address of the lookup |
| cfg_we | input | 1 | Mask register write strobe |
| cfg_id | input | 2 | Requester whose mask is written |
| cfg_mask | input | 16 | New lock mask (1 = way locked) |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | 4 | Hit way, or the way filled on a miss |
| rsp_no_alloc | output | 1 | Miss with every way locked; nothing installed |
| rsp_evict | output | 1 | A valid line was displaced |
| rsp_evict_addr | output | 32 | Line address of the displaced line |

## Verification
The assertions assume that req_id and cfg_id always name an existing requester and that req_valid, req_id and req_addr are stable around the clock edge. The bench drives every input one time unit after a rising edge and uses only the four requester numbers. The assertions also assume that a mask written in the same cycle as a request does not apply to that request. The bench therefore finishes each mask write one full cycle before the lookups that depend on it.

// File: rtl/llc_lock_pkg.sv
package llc_lock_pkg;

   // How a miss obtained its victim way
   typedef enum logic [1:0] {
      PICK_NONE    = 2'd0,
      PICK_INVALID = 2'd1,
      PICK_ROTATE  = 2'd2
   } pick_kind_e;

endpackage

// File: rtl/lock_mask_bank.sv
module lock_mask_bank #(
   parameter int unsigned NUM_REQ  = 4,
   parameter int unsigned NUM_WAYS = 16,
   localparam int unsigned ID_W    = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ID_W-1:0]     wr_id,
   input  logic [NUM_WAYS-1:0] wr_mask,
   input  logic [ID_W-1:0]     rd_id,
   output logic [NUM_WAYS-1:0] rd_mask
);

   logic [NUM_WAYS-1:0] mask_q [NUM_REQ];

   for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mask_q[r] <= '0;
         end else if (wr_en && (wr_id == ID_W'(r))) begin
            mask_q[r] <= wr_mask;
         end
      end
   end

   always_comb begin
      rd_mask = '0;
      for (int r = 0; r < NUM_REQ; r++) begin
         if (rd_id == ID_W'(r)) rd_mask = mask_q[r];
      end
   end

endmodule

// File: rtl/way_match.sv
module way_match #(
   parameter int unsigned NUM_WAYS = 16,
   parameter int unsigned TAG_W    = 16,
   localparam int unsigned WAY_W   = $clog2(NUM_WAYS)
) (
   input  logic [NUM_WAYS*TAG_W-1:0] set_tags,
   input  logic [NUM_WAYS-1:0]       set_valid,
   input  logic [TAG_W-1:0]          look_tag,
   output logic [NUM_WAYS-1:0]       match_vec,
   output logic                      match_any,
   output logic [WAY_W-1:0]          match_way
);

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
      assign match_vec[w] = set_valid[w] && (set_tags[w*TAG_W +: TAG_W] == look_tag);
   end

   assign match_any = |match_vec;

   always_comb begin
      match_way = '0;
      for (int w = 0; w < NUM_WAYS; w++) begin
         if (match_vec[w]) match_way = WAY_W'(w);
      end
   end

endmodule

// File: rtl/victim_select.sv
module victim_select
   import llc_lock_pkg::*;
#(
   parameter int unsigned NUM_WAYS = 16,
   localparam int unsigned WAY_W   = $clog2(NUM_WAYS)
) (
   input  logic [NUM_WAYS-1:0] lock_mask,
   input  logic [NUM_WAYS-1:0] set_valid,
   input  logic [WAY_W-1:0]    rot_ptr,
   output pick_kind_e          pick_kind,
   output logic [WAY_W-1:0]    pick_way,
   output logic [WAY_W-1:0]    pick_next_ptr
);

   logic [NUM_WAYS-1:0] open_ways;
   logic [NUM_WAYS-1:0] open_free;

   assign open_ways = ~lock_mask;
   assign open_free = open_ways & ~set_valid;

   always_comb begin
      logic [WAY_W-1:0] probe;
      pick_kind     = PICK_NONE;
      pick_way      = '0;
      probe         = '0;
      // lowest open invalid way wins
      for (int w = NUM_WAYS - 1; w >= 0; w--) begin
         if (open_free[w]) begin
            pick_kind = PICK_INVALID;
            pick_way  = WAY_W'(w);
         end
      end
      // otherwise first open way at or after the pointer, wrapping
      if (pick_kind == PICK_NONE) begin
         for (int k = NUM_WAYS - 1; k >= 0; k--) begin
            probe = rot_ptr + WAY_W'(k);
            if (open_ways[probe]) begin
               pick_kind = PICK_ROTATE;
               pick_way  = probe;
            end
         end
      end
      pick_next_ptr = (pick_kind == PICK_ROTATE) ? pick_way + WAY_W'(1) : rot_ptr;
   end

endmodule

// File: rtl/lockdown_llc_tags.sv
module lockdown_llc_tags
   import llc_lock_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned NUM_WAYS   = 16,
   parameter int unsigned NUM_SETS   = 2048,
   parameter int unsigned LINE_BYTES = 32,
   parameter int unsigned NUM_REQ    = 4,
   localparam int unsigned OFF_W     = $clog2(LINE_BYTES),
   localparam int unsigned SET_W     = $clog2(NUM_SETS),
   localparam int unsigned TAG_W     = ADDR_W - SET_W - OFF_W,
   localparam int unsigned WAY_W     = $clog2(NUM_WAYS),
   localparam int unsigned ID_W      = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [ID_W-1:0]     req_id,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic                cfg_we,
   input  logic [ID_W-1:0]     cfg_id,
   input  logic [NUM_WAYS-1:0] cfg_mask,
   output logic                rsp_valid,
   output logic                rsp_hit,
   output logic [WAY_W-1:0]    rsp_way,
   output logic                rsp_no_alloc,
   output logic                rsp_evict,
   output logic [ADDR_W-1:0]   rsp_evict_addr
);

   // elaboration-time parameter checks
   if (NUM_WAYS < 2 || NUM_WAYS != (1 << WAY_W)) begin : g_bad_ways
      $error("NUM_WAYS must be a power of two of at least 2");
   end
   if (NUM_SETS != (1 << SET_W)) begin : g_bad_sets
      $error("NUM_SETS must be a power of two");
   end
   if (LINE_BYTES != (1 << OFF_W)) begin : g_bad_line
      $error("LINE_BYTES must be a power of two");
   end
   if (OFF_W + SET_W < 16 || TAG_W < 1) begin : g_bad_split
      $error("set index must reach address bit 15 and leave a tag");
   end

   // tag store, valid bits and rotation pointers, one word per set
   logic [NUM_WAYS*TAG_W-1:0] tag_mem [NUM_SETS];
   logic [NUM_WAYS-1:0]       vld_mem [NUM_SETS];
   logic [WAY_W-1:0]          ptr_mem [NUM_SETS];

   logic [TAG_W-1:0]          req_tag;
   logic [SET_W-1:0]          req_set;
   logic [NUM_WAYS*TAG_W-1:0] rd_tags;
   logic [NUM_WAYS-1:0]       rd_vld;
   logic [WAY_W-1:0]          rd_ptr;
   logic [NUM_WAYS-1:0]       mask_sel;
   logic [NUM_WAYS-1:0]       hit_vec;
   logic                      hit_any;
   logic [WAY_W-1:0]          hit_way;
   pick_kind_e                vic_kind;
   logic [WAY_W-1:0]          vic_way;
   logic [WAY_W-1:0]          vic_next_ptr;
   logic                      is_miss;
   logic                      do_install;
   logic                      do_evict;
   logic [TAG_W-1:0]          old_tag;

   assign req_tag = req_addr[ADDR_W-1 -: TAG_W];
   assign req_set = req_addr[OFF_W +: SET_W];
   assign rd_tags = tag_mem[req_set];
   assign rd_vld  = vld_mem[req_set];
   assign rd_ptr  = ptr_mem[req_set];
   assign old_tag = rd_tags[vic_way*TAG_W +: TAG_W];

   lock_mask_bank #(
      .NUM_REQ  (NUM_REQ),
      .NUM_WAYS (NUM_WAYS)
   ) i_masks (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_id   (cfg_id),
      .wr_mask (cfg_mask),
      .rd_id   (req_id),
      .rd_mask (mask_sel)
   );

   way_match #(
      .NUM_WAYS (NUM_WAYS),
      .TAG_W    (TAG_W)
   ) i_match (
      .set_tags  (rd_tags),
      .set_valid (rd_vld),
      .look_tag  (req_tag),
      .match_vec (hit_vec),
      .match_any (hit_any),
      .match_way (hit_way)
   );

   victim_select #(
      .NUM_WAYS (NUM_WAYS)
   ) i_victim (
      .lock_mask     (mask_sel),
      .set_valid     (rd_vld),
      .rot_ptr       (rd_ptr),
      .pick_kind     (vic_kind),
      .pick_way      (vic_way),
      .pick_next_ptr (vic_next_ptr)
   );

   assign is_miss    = req_valid && !hit_any;
   assign do_install = is_miss && (vic_kind != PICK_NONE);
   assign do_evict   = do_install && rd_vld[vic_way];

   // state update: valid bits and pointers carry reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < NUM_SETS; s++) begin
            vld_mem[s] <= '0;
            ptr_mem[s] <= '0;
         end
      end else if (do_install) begin
         vld_mem[req_set][vic_way] <= 1'b1;
         if (vic_kind == PICK_ROTATE) ptr_mem[req_set] <= vic_next_ptr;
      end
   end

   // tag array needs no reset; valid bits qualify it
   always_ff @(posedge clk) begin
      if (do_install) tag_mem[req_set][vic_way*TAG_W +: TAG_W] <= req_tag;
   end

   // registered response
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid      <= 1'b0;
         rsp_hit        <= 1'b0;
         rsp_way        <= '0;
         rsp_no_alloc   <= 1'b0;
         rsp_evict      <= 1'b0;
         rsp_evict_addr <= '0;
      end else begin
         rsp_valid      <= req_valid;
         rsp_hit        <= req_valid && hit_any;
         rsp_way        <= !req_valid ? '0 : (hit_any ? hit_way : vic_way);
         rsp_no_alloc   <= is_miss && (vic_kind == PICK_NONE);
         rsp_evict      <= do_evict;
         rsp_evict_addr <= do_evict ? {old_tag, req_set, {OFF_W{1'b0}}} : '0;
      end
   end

   // R2
   hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> $onehot0(hit_vec));

   // R4
   invalid_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (do_install && |(~mask_sel & ~rd_vld)) |-> !rd_vld[vic_way]);

   // R5
   victim_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      do_install |-> !mask_sel[vic_way]);

   // R7
   no_alloc_full_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_miss && vic_kind == PICK_NONE) |-> (&mask_sel));

   // R8
   evict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_evict |-> (rsp_valid && !rsp_hit && !rsp_no_alloc));

   // R9
   rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R9
   rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

endmodule

// File: tb/test_lockdown_llc_tags.sv
module test_lockdown_llc_tags;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_id = '0;
   logic [31:0] req_addr = '0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_id = '0;
   logic [15:0] cfg_mask = '0;
   logic        rsp_valid;
   logic        rsp_hit;
   logic [3:0]  rsp_way;
   logic        rsp_no_alloc;
   logic        rsp_evict;
   logic [31:0] rsp_evict_addr;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   lockdown_llc_tags i_lockdown_llc_tags (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_valid      (req_valid),
      .req_id         (req_id),
      .req_addr       (req_addr),
      .cfg_we         (cfg_we),
      .cfg_id         (cfg_id),
      .cfg_mask       (cfg_mask),
      .rsp_valid      (rsp_valid),
      .rsp_hit        (rsp_hit),
      .rsp_way        (rsp_way),
      .rsp_no_alloc   (rsp_no_alloc),
      .rsp_evict      (rsp_evict),
      .rsp_evict_addr (rsp_evict_addr)
   );

   function automatic logic [31:0] mk(input logic [15:0] tag, input logic [10:0] set,
                                      input logic [4:0] off);
      return {tag, set, off};
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic cfg(input logic [1:0] id, input logic [15:0] m);
      cfg_we = 1'b1; cfg_id = id; cfg_mask = m;
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   // issue one lookup and compare the full response
   task automatic look(input string req, input logic [1:0] id, input logic [31:0] a,
                       input logic hit, input logic [3:0] way, input logic noal,
                       input logic ev, input logic [31:0] ev_addr);
      req_valid = 1'b1; req_id = id; req_addr = a;
      @(posedge clk); #1;
      req_valid = 1'b0;
      check(req, "rsp_valid", 32'(rsp_valid), 32'd1);
      check(req, "rsp_hit", 32'(rsp_hit), 32'(hit));
      check(req, "rsp_way", 32'(rsp_way), 32'(way));
      check(req, "rsp_no_alloc", 32'(rsp_no_alloc), 32'(noal));
      check(req, "rsp_evict", 32'(rsp_evict), 32'(ev));
      check(req, "rsp_evict_addr", rsp_evict_addr, ev_addr);
   endtask

   task automatic t_reset;
      check("R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
      // R1 R4: empty cache, open mask, first fill lands in way 0
      look("R1", 2'd0, mk(16'h1234, 11'h010, 5'h0), 1'b0, 4'd0, 1'b0, 1'b0, 32'h0);
   endtask

   task automatic t_timing;
      @(posedge clk); #1;
      check("R9", "rsp_valid idle cycle", 32'(rsp_valid), 32'd0);
   endtask

   task automatic t_hit_any;
      // R2: different requester hits a line it did not install
      look("R2", 2'd1, mk(16'h1234, 11'h010, 5'h0), 1'b1, 4'd0, 1'b0, 1'b0, 32'h0);
   endtask

   task automatic t_lock_one_way;
      cfg(2'd1, 16'hFFFB);
      // R10 R5: only way 2 is open for requester 1
      look("R5", 2'd1, mk(16'h2222, 11'h010, 5'h0), 1'b0, 4'd2, 1'b0, 1'b0, 32'h0);
      // R8: second miss must displace the line in way 2
      look("R8", 2'd1, mk(16'h3333, 11'h010, 5'h0), 1'b0, 4'd2, 1'b0, 1'b1,
           mk(16'h2222, 11'h010, 5'h0));
      // R2: hit in a way locked for this requester
      look("R2", 2'd1, mk(16'h1234, 11'h010, 5'h0), 1'b1, 4'd0, 1'b0, 1'b0, 32'h0);
      // R10: requester 0 still unlocked, takes lowest invalid way 1
      look("R10", 2'd0, mk(16'h4444, 11'h010, 5'h0), 1'b0, 4'd1, 1'b0, 1'b0, 32'h0);
   endtask

   task automatic t_all_locked;
      cfg(2'd2, 16'hFFFF);
      look("R7", 2'd2, mk(16'h5555, 11'h010, 5'h0), 1'b0, 4'd0, 1'b1, 1'b0, 32'h0);
      // R7: nothing installed, so it misses again
      look("R7", 2'd2, mk(16'h5555, 11'h010, 5'h0), 1'b0, 4'd0, 1'b1, 1'b0, 32'h0);
   endtask

   task automatic t_rotation;
      for (int i = 0; i < 16; i++) begin
         look("R4", 2'd0, mk(16'h0100 + 16'(i), 11'h020, 5'h0), 1'b0, 4'(i), 1'b0, 1'b0, 32'h0);
      end
      // R6: pointer starts at 0
      look("R6", 2'd0, mk(16'h0200, 11'h020, 5'h0), 1'b0, 4'd0, 1'b0, 1'b1,
           mk(16'h0100, 11'h020, 5'h0));
      look("R6", 2'd0, mk(16'h0201, 11'h020, 5'h0), 1'b0, 4'd1, 1'b0, 1'b1,
           mk(16'h0101, 11'h020, 5'h0));
      cfg(2'd3, 16'h00FF);
      // R6 R5: pointer at 2 skips locked ways 2..7
      look("R6", 2'd3, mk(16'h0202, 11'h020, 5'h0), 1'b0, 4'd8, 1'b0, 1'b1,
           mk(16'h0108, 11'h020, 5'h0));
      look("R6", 2'd3, mk(16'h0203, 11'h020, 5'h0), 1'b0, 4'd9, 1'b0, 1'b1,
           mk(16'h0109, 11'h020, 5'h0));
      look("R2", 2'd0, mk(16'h0200, 11'h020, 5'h0), 1'b1, 4'd0, 1'b0, 1'b0, 32'h0);
   endtask

   task automatic t_addr_split;
      look("R3", 2'd0, mk(16'hABCD, 11'h030, 5'h00), 1'b0, 4'd0, 1'b0, 1'b0, 32'h0);
      // R3: offset bits are ignored
      look("R3", 2'd0, mk(16'hABCD, 11'h030, 5'h1F), 1'b1, 4'd0, 1'b0, 1'b0, 32'h0);
      // R3: color bit 12 flipped selects another set
      look("R3", 2'd0, mk(16'hABCD, 11'h030, 5'h00) ^ 32'h0000_1000, 1'b0, 4'd0,
           1'b0, 1'b0, 32'h0);
      look("R3", 2'd0, mk(16'hABCD, 11'h030, 5'h00), 1'b1, 4'd0, 1'b0, 1'b0, 32'h0);
   endtask

   initial begin
      #(4 * 100000);
      if (!finished) begin
         n_fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;
      t_reset();
      t_timing();
      t_hit_any();
      t_lock_one_way();
      t_all_locked();
      t_rotation();
      t_addr_split();
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

endmodule